// File: doc/BRIEF.md
# Two-Way Skewed-Index Cache

This block is a small two-way data cache whose ways do not share a set index. The first way is looked up with the plain index bits of the address. The second way is looked up with an index formed by XOR-folding the tag bits onto those index bits. Lines that would fight over one set of the first way therefore tend to fall into separate sets of the second way. The block takes one read or write request at a time and checks both ways in the same cycle. It returns a hit or miss indication with the data. On a read miss it fetches a whole line over a line-wide memory read port.

Writes always go straight through to memory. A write that misses does not allocate a line. Each line carries a one-bit recently-used flag. The two candidate lines sit in unrelated sets, so there is no shared per-set state for replacement. The victim is chosen by comparing the two flags instead.

Top module: `skew_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid`, `mem_rd_req` and `mem_wr_en` are 0.
- R2: A word address is split into three fields. The low `OFF_W` bits select the word in the line. The next `IDX_W` bits are the index. The remaining `TAG_W` bits are the tag. With the defaults these are bit 0, bits 3:1 and bits 9:4. Way 0 uses the index directly. Way 1 uses the index XORed with every `IDX_W`-bit chunk of the zero-padded tag; with the defaults this is `idx ^ tag[2:0] ^ tag[5:3]`. Way 1 stores the whole line address as its tag.
- R3: A hit in either way returns `resp_valid`=1 and `resp_hit`=1 exactly two clock edges after the edge that accepted the request. A read hit also returns the cached word.
- R4: On a read miss, `mem_rd_req` is held high with a stable line address until `mem_rd_valid`. At the next edge the block returns `resp_hit`=0 with the requested word from the fetched line, and it installs that line.
- R5: Every write drives `mem_wr_en` high for one cycle, with the write's address and data, in the same cycle as its response. A read never drives `mem_wr_en`.
- R6: A write miss changes no line and no flag. A later read of that address misses and returns the written value.
- R7: A write hit replaces the addressed word in the cached line, so later read hits return the new value.
- R8: On a read miss the victim is chosen in this order: way 0 if its candidate is invalid; otherwise way 1 if its candidate is invalid; otherwise way 1 if only the way-0 flag is set; otherwise way 0.
- R9: On a hit or a fill, the accessed candidate's flag becomes 1 and the other way's candidate flag becomes 0.
- R10: A line is never resident in both ways at once.
- R11: Only one request is in flight. `req_ready` is 0 from the accepting edge until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | DATA_W | Read data |
| mem_rd_req | output | 1 | Line fetch request, held until served |
| mem_rd_addr | output | ADDR_W-OFF_W | Line address to fetch |
| mem_rd_valid | input | 1 | Fetched line is present |
| mem_rd_line | input | DATA_W<<OFF_W | Fetched line, word 0 in the low bits |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through word address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The assertions check the following on every cycle:
- a hit answers two edges after acceptance;
- a fetch request stays up with a steady address until served;
- a served fetch is followed by a miss response;
- write-through strobes occur only in response cycles;
- the block stays busy while a request is in flight;
- the two ways never both match one address.

Index skewing, victim choice, flag updates, write merging and no-allocate on write only show up in hit and miss sequences. The bench covers these with a reference cache model. It drives a full sequential sweep, a 64-tag conflict sweep on one index, directed skew and no-allocate cases, and a long mixed read/write stream.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } cache_state_e;

    typedef struct packed {
        logic hit0;
        logic hit1;
        logic victim;   // 0 = way 0, 1 = way 1
    } lookup_t;

    // Victim order: invalid way 0, invalid way 1, the clear flag, ties go to way 0.
    function automatic logic pick_victim(input logic v0, input logic v1,
                                         input logic u0, input logic u1);
        if (!v0)          return 1'b0;
        else if (!v1)     return 1'b1;
        else if (u0 && !u1) return 1'b1;
        else              return 1'b0;
    endfunction

endpackage

// File: rtl/skew_hash.sv
module skew_hash #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic [IDX_W-1:0] hidx
);
    localparam int NCH = (TAG_W + IDX_W - 1) / IDX_W;

    logic [NCH*IDX_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[TAG_W-1:0] = tag;
        hidx = idx;
        for (int k = 0; k < NCH; k++) begin
            hidx = hidx ^ padded[k*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/skew_way.sv
module skew_way #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 6,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_used,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              flag_en,
    input  logic [IDX_W-1:0]  flag_idx,
    input  logic              flag_val
);
    localparam int SETS = 1 << IDX_W;

    logic              valid_q [SETS];
    logic              used_q  [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS];
    logic [LINE_W-1:0] line_q  [SETS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_used  = used_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) begin
                valid_q[i] <= 1'b0;
                used_q[i]  <= 1'b0;
            end
        end else begin
            if (flag_en) used_q[flag_idx] <= flag_val;
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
                used_q[wr_idx]  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/skew_cache.sv
module skew_cache
    import skew_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 1,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_we,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        req_ready,
    output logic                        resp_valid,
    output logic                        resp_hit,
    output logic [DATA_W-1:0]           resp_rdata,
    output logic                        mem_rd_req,
    output logic [ADDR_W-OFF_W-1:0]     mem_rd_addr,
    input  logic                        mem_rd_valid,
    input  logic [(DATA_W<<OFF_W)-1:0]  mem_rd_line,
    output logic                        mem_wr_en,
    output logic [ADDR_W-1:0]           mem_wr_addr,
    output logic [DATA_W-1:0]           mem_wr_data
);
    localparam int LINE_W  = DATA_W << OFF_W;
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;

    cache_state_e      st_q;
    logic              s_we;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;
    logic [IDX_W-1:0]  s_hidx;
    logic [IDX_W-1:0]  req_hidx;

    logic [OFF_W-1:0]   s_off;
    logic [IDX_W-1:0]   s_idx;
    logic [TAG_W-1:0]   s_tag;
    logic [LADDR_W-1:0] s_laddr;

    assign s_off   = s_addr[OFF_W-1:0];
    assign s_idx   = s_addr[OFF_W +: IDX_W];
    assign s_tag   = s_addr[ADDR_W-1 -: TAG_W];
    assign s_laddr = s_addr[ADDR_W-1:OFF_W];

    // Way-1 index hashing happens before the request register (extra stage on that path).
    skew_hash #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash (
        .idx  (req_addr[OFF_W +: IDX_W]),
        .tag  (req_addr[ADDR_W-1 -: TAG_W]),
        .hidx (req_hidx)
    );

    logic              v0, v1, u0, u1;
    logic [TAG_W-1:0]  t0;
    logic [LADDR_W-1:0] t1;
    logic [LINE_W-1:0] l0, l1;
    logic              w0_en, w1_en, f0_en, f1_en, acc0;
    logic [LINE_W-1:0] wr_line;
    logic [LINE_W-1:0] hit_line, merged;
    lookup_t           lk;
    logic              look, fill_done, any_hit;
    logic              hit0, hit1;

    skew_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way0 (
        .clk, .rst,
        .rd_idx (s_idx), .rd_valid(v0), .rd_used(u0), .rd_tag(t0), .rd_line(l0),
        .wr_en (w0_en), .wr_idx(s_idx), .wr_tag(s_tag), .wr_line(wr_line),
        .flag_en(f0_en), .flag_idx(s_idx), .flag_val(acc0)
    );

    skew_way #(.IDX_W(IDX_W), .TAG_W(LADDR_W), .LINE_W(LINE_W)) u_way1 (
        .clk, .rst,
        .rd_idx (s_hidx), .rd_valid(v1), .rd_used(u1), .rd_tag(t1), .rd_line(l1),
        .wr_en (w1_en), .wr_idx(s_hidx), .wr_tag(s_laddr), .wr_line(wr_line),
        .flag_en(f1_en), .flag_idx(s_hidx), .flag_val(!acc0)
    );

    always_comb begin
        lk.hit0   = v0 && (t0 == s_tag);
        lk.hit1   = v1 && (t1 == s_laddr);
        lk.victim = pick_victim(v0, v1, u0, u1);
        hit0      = lk.hit0;
        hit1      = lk.hit1;
        any_hit   = lk.hit0 || lk.hit1;
        look      = (st_q == ST_LOOK);
        fill_done = (st_q == ST_FILL) && mem_rd_valid;
        hit_line  = lk.hit0 ? l0 : l1;
        merged    = hit_line;
        merged[s_off*DATA_W +: DATA_W] = s_wdata;
        wr_line   = look ? merged : mem_rd_line;
        w0_en     = (look && s_we && lk.hit0) || (fill_done && !lk.victim);
        w1_en     = (look && s_we && lk.hit1) || (fill_done && lk.victim);
        acc0      = look ? lk.hit0 : !lk.victim;
        f0_en     = (look && any_hit) || fill_done;
        f1_en     = f0_en;
    end

    assign req_ready   = (st_q == ST_IDLE);
    assign mem_rd_req  = (st_q == ST_FILL);
    assign mem_rd_addr = s_laddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            s_we        <= 1'b0;
            s_addr      <= '0;
            s_wdata     <= '0;
            s_hidx      <= '0;
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_rdata  <= '0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            resp_valid <= (look && (s_we || any_hit)) || fill_done;
            resp_hit   <= look && any_hit;
            mem_wr_en  <= look && s_we;
            if (look) begin
                resp_rdata  <= s_we ? s_wdata : hit_line[s_off*DATA_W +: DATA_W];
                mem_wr_addr <= s_addr;
                mem_wr_data <= s_wdata;
            end else if (fill_done) begin
                resp_rdata <= mem_rd_line[s_off*DATA_W +: DATA_W];
            end
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    st_q    <= ST_LOOK;
                    s_we    <= req_we;
                    s_addr  <= req_addr;
                    s_wdata <= req_wdata;
                    s_hidx  <= req_hidx;
                end
                ST_LOOK: st_q <= (!s_we && !any_hit) ? ST_FILL : ST_IDLE;
                ST_FILL: if (mem_rd_valid) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/skew_cache_chk.sv
module skew_cache_chk #(
    parameter int LADDR_W = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               mem_rd_req,
    input logic               mem_rd_valid,
    input logic [LADDR_W-1:0] mem_rd_addr,
    input logic               mem_wr_en,
    input logic               look,
    input logic               hit0,
    input logic               hit1
);
    a_r3_hit_two_edges: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> $past(req_valid && req_ready, 2));

    a_r4_fetch_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r4_fill_answers_miss: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid) |=> (resp_valid && !resp_hit));

    a_r5_write_with_resp: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> resp_valid);

    a_r11_single_flight: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_no_fetch_when_ready: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready);

    a_r10_exclusive_ways: assert property (@(posedge clk) disable iff (rst)
        look |-> !(hit0 && hit1));
endmodule

bind skew_cache skew_cache_chk #(.LADDR_W(LADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_wr_en    (mem_wr_en),
    .look         (look),
    .hit0         (hit0),
    .hit1         (hit1)
);

// File: tb/tb_skew_cache.sv
module tb_skew_cache;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_we = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, resp_valid, resp_hit;
    logic [7:0] resp_rdata;
    logic       mem_rd_req;
    logic [8:0] mem_rd_addr;
    logic       mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_line = '0;
    logic       mem_wr_en;
    logic [9:0] mem_wr_addr;
    logic [7:0] mem_wr_data;

    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    skew_cache dut (
        .clk, .rst, .req_valid, .req_we, .req_addr, .req_wdata, .req_ready,
        .resp_valid, .resp_hit, .resp_rdata, .mem_rd_req, .mem_rd_addr,
        .mem_rd_valid, .mem_rd_line, .mem_wr_en, .mem_wr_addr, .mem_wr_data
    );

    // Backing store driven by the block's own memory ports.
    logic [7:0] mm   [1024];
    logic [7:0] refm [1024];
    int         lat_cnt = 0;

    always @(posedge clk) begin
        if (mem_wr_en) mm[mem_wr_addr] <= mem_wr_data;
        if (mem_rd_req && !mem_rd_valid) begin
            if (lat_cnt == 2) begin
                mem_rd_valid <= 1'b1;
                mem_rd_line  <= {mm[{mem_rd_addr, 1'b1}], mm[{mem_rd_addr, 1'b0}]};
                lat_cnt      <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_rd_valid <= 1'b0;
            lat_cnt      <= 0;
        end
    end

    // Reference cache state.
    bit       m0_v [8], m0_u [8], m1_v [8], m1_u [8];
    bit [5:0] m0_t [8];
    bit [8:0] m1_t [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [9:0] a, input logic [7:0] wd,
                          input string req);
        logic [2:0] idx;
        logic [5:0] tg;
        logic [2:0] h;
        bit h0, h1, vic, exp_hit;
        int lat;
        idx = a[3:1];
        tg  = a[9:4];
        h   = idx ^ tg[2:0] ^ tg[5:3];
        h0  = m0_v[idx] && (m0_t[idx] == tg);
        h1  = m1_v[h] && (m1_t[h] == a[9:1]);
        exp_hit = h0 || h1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(posedge clk); lat = 1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
        while (!resp_valid && lat < 40) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        chk(resp_valid == 1'b1, req, "response seen", resp_valid, 1);
        chk(resp_hit == exp_hit, req, "hit flag", resp_hit, exp_hit);
        if (exp_hit) chk(lat == 2, "R3", "hit latency", lat, 2);
        if (we) begin
            chk(mem_wr_en == 1'b1, "R5", "write strobe", mem_wr_en, 1);
            chk(mem_wr_addr == a && mem_wr_data == wd, "R5", "write addr/data",
                {mem_wr_addr, mem_wr_data}, {a, wd});
            refm[a] = wd;
        end else begin
            chk(mem_wr_en == 1'b0, "R5", "no strobe on read", mem_wr_en, 0);
            chk(resp_rdata == refm[a], exp_hit ? "R7" : "R4", "read data",
                resp_rdata, refm[a]);
        end
        // Model update (R8, R9, R6).
        if (h0) begin m0_u[idx] = 1; m1_u[h] = 0; end
        else if (h1) begin m1_u[h] = 1; m0_u[idx] = 0; end
        else if (!we) begin
            if (!m0_v[idx]) vic = 0;
            else if (!m1_v[h]) vic = 1;
            else if (m0_u[idx] && !m1_u[h]) vic = 1;
            else vic = 0;
            if (!vic) begin m0_v[idx] = 1; m0_t[idx] = tg; m0_u[idx] = 1; m1_u[h] = 0; end
            else begin m1_v[h] = 1; m1_t[h] = a[9:1]; m1_u[h] = 1; m0_u[idx] = 0; end
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 1024; i++) begin
            mm[i]   = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 8; i++) begin
            m0_v[i] = 0; m0_u[i] = 0; m1_v[i] = 0; m1_u[i] = 0;
            m0_t[i] = '0; m1_t[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0 && mem_rd_req == 1'b0 && mem_wr_en == 1'b0, "R1",
            "idle outputs", {resp_valid, mem_rd_req, mem_wr_en}, 0);

        // R2 skew: two tags sharing index 0 go to different ways and both stay.
        access(0, 10'h010, 0, "R8");
        access(0, 10'h020, 0, "R8");
        access(0, 10'h010, 0, "R2");
        access(0, 10'h020, 0, "R2");
        access(0, 10'h021, 0, "R2");

        // R6: write miss, then read returns written value and misses.
        access(1, 10'h3F6, 8'hA5, "R6");
        access(0, 10'h3F6, 0, "R6");
        // R7: write hit then read hit.
        access(1, 10'h3F7, 8'h5A, "R7");
        access(0, 10'h3F7, 0, "R7");

        // Full sequential read sweep.
        for (int a = 0; a < 1024; a++) access(0, 10'(a), 0, "R4");

        // Conflict sweep on index 5, forward and back.
        for (int t = 0; t < 64; t++) access(0, {6'(t), 3'd5, 1'b0}, 0, "R8");
        for (int t = 63; t >= 0; t--) access(0, {6'(t), 3'd5, 1'b1}, 0, "R9");

        // Mixed stream over a small address range, then a wider one.
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            access(lf[9] & lf[8], (n < 2000) ? {3'b0, lf[6:0]} : lf[9:0], lf[15:8], "R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule